// File: doc/BRIEF.md
# Serial Port Edge Polarity Engine

A synchronous serial port channel with a receive half and a transmit half, clocked from the system clock. The external serial clock, both frame-sync lines and the receive data line are brought into the system clock domain through a two-flop synchronizer. Rising and falling serial clock edges are found by comparing successive synchronized samples.

A 2-bit polarity code picks two edges separately: the serial clock edge on which data is handled and the edge on which frame syncs are handled. The receiver samples on the chosen edges. The transmitter always works on the opposite edges, so the four codes give four distinct pairings of data and sync edges.

Words of 4 to 32 bits move most-significant bit first. On the parallel side, received words leave over a valid/ready handshake and transmit words arrive over one. A word that finds the output still occupied sets a sticky overflow flag. A transmit frame that starts with no word loaded sets a sticky underflow flag.

Top module: `sport_edge_port`

## Requirements
- R1: `pol[1]` picks the receive data edge and `pol[0]` picks the receive frame-sync edge, each with 1 = rising serial clock edge and 0 = falling. Codes 00, 01, 10 and 11 therefore give falling/falling, falling/rising, rising/falling and rising/rising (data/sync).
- R2: The transmitter drives `tx_sd` on the serial clock edge opposite to the receive data edge. It samples `tx_fs_in` on the edge opposite to the receive sync edge.
- R3: `sclk_in`, `rx_fs_in`, `tx_fs_in` and `rx_sd_in` pass through a two-flop synchronizer. A pin edge takes effect at the third rising system clock edge after it, so `rx_valid` rises on the third system clock edge after the serial edge that samples a word's last bit.
- R4: A high `rx_fs_in` seen on the receive sync edge marks a frame. The first bit is captured on the first receive data edge strictly after that sync edge. Bits arrive MSB first, and the word is right-aligned in `rx_data` with the unused upper bits zero.
- R5: The word length is `word_len` clamped to the range 4 to 32.
- R6: `rx_valid` stays high, with `rx_data` unchanged, until a system clock edge where `rx_ready` is high.
- R7: A word completed while `rx_valid` is high and `rx_ready` is low is discarded, and `rx_overflow` is set. The flag holds until a cycle with `rx_overflow_clr` high and no new overflow.
- R8: `tx_ready` is high while the one-word transmit holding register is empty. A word is accepted on an edge where `tx_valid` and `tx_ready` are both high, and moves to the shifter when a transmit frame starts.
- R9: A transmit frame that starts with the holding register empty sends all zeros and sets `tx_underflow`. The flag holds until a cycle with `tx_underflow_clr` high and no new underflow.
- R10: While `enable` is low, both shifters, both bit counters and any marked frame are cleared, and `tx_sd` is driven low. The flags, the holding register and the receive output are kept.
- R11: `tx_sd` carries the MSB from the first transmit data edge after the transmit frame start, and one bit per transmit data edge after that. It returns low on the next transmit data edge after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable; low clears the serial state |
| pol | input | 2 | Edge polarity code (change only while disabled) |
| word_len | input | 6 | Requested bits per word |
| sclk_in | input | 1 | External serial clock |
| rx_fs_in | input | 1 | Receive frame sync, active high |
| rx_sd_in | input | 1 | Receive serial data |
| tx_fs_in | input | 1 | Transmit frame sync, active high |
| rx_data | output | 32 | Received word, right-aligned |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Consumer takes the received word |
| tx_data | input | 32 | Word to transmit, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| tx_sd | output | 1 | Transmit serial data |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| rx_overflow_clr | input | 1 | Clears `rx_overflow` |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| tx_underflow_clr | input | 1 | Clears `tx_underflow` |

## Verification
Each serial event shows up at the outputs three system clock edges after the pin moves. That delay covers two synchronizer flops and then the register that acts on the edge. It applies to an update of `rx_valid`/`rx_data`, a new `tx_sd` bit and a flag setting alike. Handshake and clear effects appear one edge after the inputs that cause them.

The bench runs a behavioural model that carries the same three-edge pipeline as integer state. It compares every output at each falling system clock edge, halfway between the edges where results change. A directed check samples `rx_valid` two and three falling edges after the last serial data edge to pin down that delay. A queue of expected words checks content and order independently of cycle timing.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;

    localparam int unsigned MAX_WORD = 32;
    localparam int unsigned MIN_WORD = 4;

    // synchronized pin bundle
    typedef struct packed {
        logic rx_sd;
        logic tx_fs;
        logic rx_fs;
        logic sclk;
    } pins_t;

    // 1 = act on rising serial clock edge, 0 = falling
    typedef struct packed {
        logic rx_data;
        logic rx_sync;
        logic tx_data;
        logic tx_sync;
    } edge_sel_t;

    function automatic edge_sel_t decode_pol(input logic [1:0] code);
        edge_sel_t e;
        e.rx_data = code[1];
        e.rx_sync = code[0];
        e.tx_data = ~code[1];
        e.tx_sync = ~code[0];
        return e;
    endfunction

    function automatic logic pick_edge(input logic use_rise, input logic rise, input logic fall);
        return use_rise ? rise : fall;
    endfunction

    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned max_bits);
        if (req < MIN_WORD) return MIN_WORD;
        if (req > max_bits) return max_bits;
        return req;
    endfunction

endpackage

// File: rtl/sport_pin_sync.sv
`timescale 1ns/1ps
module sport_pin_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    // pipe[0] is the first flop; pipe[STAGES] is the extra history stage
    logic [STAGES:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], pins};
    end

    assign cur  = pipe[STAGES-1];
    assign prev = pipe[STAGES];
endmodule

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
module sport_rx #(
    parameter int unsigned MAX_BITS = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic [$clog2(MAX_BITS+1)-1:0]  len,
    input  logic                           data_edge,
    input  logic                           sync_edge,
    input  logic                           fs_lvl,
    input  logic                           sd_lvl,
    input  logic                           ready,
    input  logic                           ovf_clr,
    output logic [MAX_BITS-1:0]            data,
    output logic                           valid,
    output logic                           ovf
);
    localparam int unsigned LW = $clog2(MAX_BITS+1);

    logic                pending;
    logic [LW-1:0]       left;
    logic [MAX_BITS-1:0] sh;
    logic [MAX_BITS-1:0] word_c;
    logic                done;
    logic                drop;

    assign word_c = {sh[MAX_BITS-2:0], sd_lvl};
    assign done   = en && data_edge && !pending && (left == LW'(1));
    assign drop   = done && valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            left    <= '0;
            sh      <= '0;
        end else if (!en) begin
            pending <= 1'b0;
            left    <= '0;
            sh      <= '0;
        end else begin
            if (data_edge) begin
                if (pending) begin
                    sh      <= {{(MAX_BITS-1){1'b0}}, sd_lvl};
                    left    <= len - LW'(1);
                    pending <= 1'b0;
                end else if (left != '0) begin
                    sh   <= word_c;
                    left <= left - LW'(1);
                end
            end
            if (sync_edge && fs_lvl) pending <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (valid && ready) valid <= 1'b0;
            if (done && (!valid || ready)) begin
                data  <= word_c;
                valid <= 1'b1;
            end
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx #(
    parameter int unsigned MAX_BITS = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic [$clog2(MAX_BITS+1)-1:0]  len,
    input  logic                           data_edge,
    input  logic                           sync_edge,
    input  logic                           fs_lvl,
    input  logic [MAX_BITS-1:0]            wdata,
    input  logic                           wvalid,
    output logic                           wready,
    input  logic                           udf_clr,
    output logic                           sd,
    output logic                           udf
);
    localparam int unsigned LW = $clog2(MAX_BITS+1);
    localparam int unsigned IW = $clog2(MAX_BITS);

    logic [MAX_BITS-1:0] hold;
    logic                hold_full;
    logic                pending;
    logic [LW-1:0]       left;
    logic [MAX_BITS-1:0] sh;
    logic                start;
    logic                starve;

    assign wready = !hold_full;
    assign start  = en && sync_edge && fs_lvl;
    assign starve = start && !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wvalid && !hold_full) begin
                hold      <= wdata;
                hold_full <= 1'b1;
            end
            if (start && hold_full) hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pending <= 1'b0;
            left    <= '0;
            sh      <= '0;
            sd      <= 1'b0;
        end else begin
            if (data_edge) begin
                if (pending) begin
                    sd      <= sh[IW'(len - LW'(1))];
                    left    <= len - LW'(1);
                    pending <= 1'b0;
                end else if (left != '0) begin
                    sd   <= sh[IW'(left - LW'(1))];
                    left <= left - LW'(1);
                end else begin
                    sd <= 1'b0;
                end
            end
            if (start) begin
                pending <= 1'b1;
                sh      <= hold_full ? hold : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          udf <= 1'b0;
        else if (starve)  udf <= 1'b1;
        else if (udf_clr) udf <= 1'b0;
    end
endmodule

// File: rtl/sport_edge_port.sv
`timescale 1ns/1ps
module sport_edge_port
    import sport_pkg::*;
#(
    parameter int unsigned MAX_BITS    = sport_pkg::MAX_WORD,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          enable,
    input  logic [1:0]                    pol,
    input  logic [$clog2(MAX_BITS+1)-1:0] word_len,
    input  logic                          sclk_in,
    input  logic                          rx_fs_in,
    input  logic                          rx_sd_in,
    input  logic                          tx_fs_in,
    output logic [MAX_BITS-1:0]           rx_data,
    output logic                          rx_valid,
    input  logic                          rx_ready,
    input  logic [MAX_BITS-1:0]           tx_data,
    input  logic                          tx_valid,
    output logic                          tx_ready,
    output logic                          tx_sd,
    output logic                          rx_overflow,
    input  logic                          rx_overflow_clr,
    output logic                          tx_underflow,
    input  logic                          tx_underflow_clr
);
    localparam int unsigned LW = $clog2(MAX_BITS+1);

    pins_t     raw, cur, prev;
    edge_sel_t sel;
    logic      sclk_rise, sclk_fall;
    logic      rx_dedge, rx_sedge, tx_dedge, tx_sedge;
    logic [LW-1:0] len_c;

    assign raw = '{rx_sd: rx_sd_in, tx_fs: tx_fs_in, rx_fs: rx_fs_in, sclk: sclk_in};

    sport_pin_sync #(.WIDTH($bits(pins_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pins(raw),
        .cur (cur),
        .prev(prev)
    );

    assign sclk_rise = cur.sclk & ~prev.sclk;
    assign sclk_fall = ~cur.sclk & prev.sclk;
    assign sel       = decode_pol(pol);
    assign rx_dedge  = pick_edge(sel.rx_data, sclk_rise, sclk_fall);
    assign rx_sedge  = pick_edge(sel.rx_sync, sclk_rise, sclk_fall);
    assign tx_dedge  = pick_edge(sel.tx_data, sclk_rise, sclk_fall);
    assign tx_sedge  = pick_edge(sel.tx_sync, sclk_rise, sclk_fall);
    assign len_c     = LW'(clamp_len(32'(word_len), MAX_BITS));

    sport_rx #(.MAX_BITS(MAX_BITS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .len      (len_c),
        .data_edge(rx_dedge),
        .sync_edge(rx_sedge),
        .fs_lvl   (cur.rx_fs),
        .sd_lvl   (cur.rx_sd),
        .ready    (rx_ready),
        .ovf_clr  (rx_overflow_clr),
        .data     (rx_data),
        .valid    (rx_valid),
        .ovf      (rx_overflow)
    );

    sport_tx #(.MAX_BITS(MAX_BITS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .len      (len_c),
        .data_edge(tx_dedge),
        .sync_edge(tx_sedge),
        .fs_lvl   (cur.tx_fs),
        .wdata    (tx_data),
        .wvalid   (tx_valid),
        .wready   (tx_ready),
        .udf_clr  (tx_underflow_clr),
        .sd       (tx_sd),
        .udf      (tx_underflow)
    );
endmodule

// File: rtl/sport_edge_port_chk.sv
`timescale 1ns/1ps
module sport_edge_port_chk #(
    parameter int unsigned MAX_BITS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                enable,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_valid,
    input logic                rx_ready,
    input logic                rx_overflow,
    input logic                rx_overflow_clr,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic                tx_sd,
    input logic                tx_underflow,
    input logic                tx_underflow_clr
);
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R6

    AST_RX_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(enable)); // R4

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overflow) |-> $past(rx_valid && !rx_ready)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_overflow && !rx_overflow_clr |=> rx_overflow); // R7

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        tx_underflow && !tx_underflow_clr |=> tx_underflow); // R9

    AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready |=> !tx_ready); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !tx_sd); // R10
endmodule

bind sport_edge_port sport_edge_port_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .enable          (enable),
    .rx_data         (rx_data),
    .rx_valid        (rx_valid),
    .rx_ready        (rx_ready),
    .rx_overflow     (rx_overflow),
    .rx_overflow_clr (rx_overflow_clr),
    .tx_valid        (tx_valid),
    .tx_ready        (tx_ready),
    .tx_sd           (tx_sd),
    .tx_underflow    (tx_underflow),
    .tx_underflow_clr(tx_underflow_clr)
);

// File: tb/tb_sport_edge_port.sv
`timescale 1ns/1ps
module tb_sport_edge_port;
    localparam int MB = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, enable = 1'b0;
    logic [1:0]  pol = 2'b00;
    logic [5:0]  word_len = 6'd8;
    logic        sclk = 1'b0, rfs = 1'b0, rsd = 1'b0, tfs = 1'b0;
    logic [31:0] rx_data;
    logic        rx_valid, rx_ready = 1'b1;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0, tx_ready, tx_sd;
    logic        rx_overflow, rx_overflow_clr = 1'b0;
    logic        tx_underflow, tx_underflow_clr = 1'b0;

    sport_edge_port dut (
        .clk(clk), .rst(rst), .enable(enable), .pol(pol), .word_len(word_len),
        .sclk_in(sclk), .rx_fs_in(rfs), .rx_sd_in(rsd), .tx_fs_in(tfs),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sd(tx_sd),
        .rx_overflow(rx_overflow), .rx_overflow_clr(rx_overflow_clr),
        .tx_underflow(tx_underflow), .tx_underflow_clr(tx_underflow_clr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [3:0]  h1, h2, h3;           // pin history: {rsd,tfs,rfs,sclk}
    int          r_left, t_left, L;
    bit          r_pend, t_pend, t_full;
    logic [31:0] r_sh, t_sh, t_hold, word;
    logic [31:0] e_rx_data;
    bit          e_rx_valid, e_ovf, e_udf, e_tx_sd;
    bit          rise, fall, rxd, rxs, txd, txs, fin, old_valid, old_full, starve;

    always @(posedge clk) begin
        if (rst) begin
            h1 = 0; h2 = 0; h3 = 0;
            r_left = 0; t_left = 0; r_pend = 0; t_pend = 0; t_full = 0;
            r_sh = 0; t_sh = 0; t_hold = 0;
            e_rx_data = 0; e_rx_valid = 0; e_ovf = 0; e_udf = 0; e_tx_sd = 0;
        end else begin
            rise = h2[0] && !h3[0];
            fall = !h2[0] && h3[0];
            rxd = pol[1] ? rise : fall;
            rxs = pol[0] ? rise : fall;
            txd = pol[1] ? fall : rise;
            txs = pol[0] ? fall : rise;
            L = (word_len < 4) ? 4 : (word_len > 32) ? 32 : int'(word_len);
            fin = 0;
            old_valid = e_rx_valid;
            old_full = t_full;
            starve = 0;
            if (enable) begin
                if (rxd) begin
                    if (r_pend) begin r_sh = {31'b0, h2[3]}; r_left = L - 1; r_pend = 0; end
                    else if (r_left > 0) begin
                        word = {r_sh[30:0], h2[3]};
                        r_sh = word;
                        if (r_left == 1) fin = 1;
                        r_left--;
                    end
                end
                if (rxs && h2[1]) r_pend = 1;
                if (txd) begin
                    if (t_pend) begin e_tx_sd = t_sh[L-1]; t_left = L - 1; t_pend = 0; end
                    else if (t_left > 0) begin e_tx_sd = t_sh[t_left-1]; t_left--; end
                    else e_tx_sd = 0;
                end
                if (txs && h2[2]) begin
                    t_pend = 1;
                    if (old_full) begin t_sh = t_hold; t_full = 0; end
                    else begin t_sh = 0; starve = 1; end
                end
            end else begin
                r_pend = 0; r_left = 0; r_sh = 0;
                t_pend = 0; t_left = 0; t_sh = 0; e_tx_sd = 0;
            end
            if (tx_valid && !old_full) begin t_hold = tx_data; t_full = 1; end
            if (old_valid && rx_ready) e_rx_valid = 0;
            if (fin) begin
                if (!old_valid || rx_ready) begin e_rx_data = word; e_rx_valid = 1; end
            end
            if (fin && old_valid && !rx_ready) e_ovf = 1;
            else if (rx_overflow_clr) e_ovf = 0;
            if (starve) e_udf = 1;
            else if (tx_underflow_clr) e_udf = 0;
            h3 = h2; h2 = h1; h1 = {rsd, tfs, rfs, sclk};
        end
    end

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(rx_valid == e_rx_valid, "R6 rx_valid", rx_valid, e_rx_valid);
            chk(rx_data == e_rx_data, "R4 rx_data", rx_data, e_rx_data);
            chk(tx_sd == e_tx_sd, "R11 tx_sd", tx_sd, e_tx_sd);
            chk(tx_ready == !t_full, "R8 tx_ready", tx_ready, !t_full);
            chk(rx_overflow == e_ovf, "R7 rx_overflow", rx_overflow, e_ovf);
            chk(tx_underflow == e_udf, "R9 tx_underflow", tx_underflow, e_udf);
        end
    end

    // expected-word queue, independent of timing
    logic [31:0] exp_q[$];
    always @(negedge clk) begin
        if (!rst && !finished && rx_valid && rx_ready) begin
            if (exp_q.size() == 0) chk(0, "R1 unexpected rx word", rx_data, 0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R1 rx word content", rx_data, e);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        repeat (8) @(negedge clk);
        sclk = ~sclk;
    endtask

    function automatic logic [31:0] mask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    endfunction

    task automatic load_tx(input logic [31:0] w);
        while (!tx_ready) @(negedge clk);
        tx_data = w;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // one frame: bits sent on the receive side, tx frame sync on the opposite sync edge
    task automatic frame(input int n, input logic [31:0] w, input bit push,
                         input int abort_at, input bit chk_lat);
        bit d_r, s_r;
        int k;
        d_r = pol[1];
        s_r = pol[0];
        do step(); while (sclk == s_r);
        rfs = 1'b1;
        do step(); while (sclk != s_r);
        tfs = 1'b1;
        k = 0;
        if (d_r != s_r) begin rsd = w[n-1]; k = 1; end
        while (k < n) begin
            step();
            rfs = 1'b0;
            if (sclk == s_r) tfs = 1'b0;
            if (sclk != d_r) begin
                if (abort_at > 0 && k == abort_at) begin
                    enable = 1'b0;
                    tfs = 1'b0;
                    return;
                end
                rsd = w[n-1-k];
                k++;
            end
        end
        if (push) exp_q.push_back(w & mask(n));
        do step(); while (sclk != d_r);
        tfs = 1'b0;
        if (chk_lat) begin
            @(negedge clk);
            @(negedge clk);
            chk(rx_valid == 1'b0, "R3 rx_valid two edges after last bit", rx_valid, 0);
            @(negedge clk);
            chk(rx_valid == 1'b1, "R3 rx_valid three edges after last bit", rx_valid, 1);
        end
    endtask

    task automatic settle();
        repeat (4) step();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_valid == 0, "R6 reset rx_valid", rx_valid, 0);
        chk(tx_ready == 1, "R8 reset tx_ready", tx_ready, 1);
        chk(tx_sd == 0, "R11 reset tx_sd", tx_sd, 0);
        chk(rx_overflow == 0 && tx_underflow == 0, "R7 reset flags", {rx_overflow, tx_underflow}, 0);

        // R1 / R2: every polarity code, 8-bit words
        for (int p = 0; p < 4; p++) begin
            pol = 2'(p);
            word_len = 6'd8;
            enable = 1'b1;
            load_tx(32'h0000_00B4 ^ 32'(p * 17));
            frame(8, 32'h0000_005A ^ 32'(p * 29), 1, 0, p == 0);
            settle();
        end

        // R5: full width, minimum width, clamping below and above
        pol = 2'b10; word_len = 6'd32; enable = 1'b1;
        load_tx(32'hDEAD_BEEF);
        frame(32, 32'hC3A5_96F1, 1, 0, 0);
        settle();

        pol = 2'b01; word_len = 6'd4; enable = 1'b1;
        load_tx(32'h0000_0009);
        frame(4, 32'h0000_000B, 1, 0, 0);
        settle();

        pol = 2'b11; word_len = 6'd2; enable = 1'b1;
        load_tx(32'h0000_0006);
        frame(4, 32'h0000_000D, 1, 0, 0);
        settle();

        pol = 2'b00; word_len = 6'd40; enable = 1'b1;
        load_tx(32'h8000_0001);
        frame(32, 32'h1234_5678, 1, 0, 0);
        settle();

        // R8: holding register accepts once
        enable = 1'b1; word_len = 6'd8;
        load_tx(32'h0000_0077);
        chk(tx_ready == 0, "R8 tx_ready low after accept", tx_ready, 0);
        frame(8, 32'h0000_0011, 1, 0, 0);
        settle();
        chk(tx_ready == 1, "R8 tx_ready back after frame start", tx_ready, 1);

        // R9: frame with nothing loaded
        enable = 1'b1;
        frame(8, 32'h0000_00E7, 1, 0, 0);
        settle();
        chk(tx_underflow == 1, "R9 underflow set", tx_underflow, 1);
        tx_underflow_clr = 1'b1;
        @(negedge clk);
        tx_underflow_clr = 1'b0;
        @(negedge clk);
        chk(tx_underflow == 0, "R9 underflow cleared", tx_underflow, 0);

        // R7: overflow while consumer stalls
        rx_ready = 1'b0; enable = 1'b1;
        load_tx(32'h0000_0033);
        frame(8, 32'h0000_0096, 1, 0, 0);
        load_tx(32'h0000_0044);
        frame(8, 32'h0000_0069, 0, 0, 0);
        settle();
        chk(rx_overflow == 1, "R7 overflow set", rx_overflow, 1);
        chk(rx_data == 32'h96, "R7 first word kept", rx_data, 32'h96);
        rx_overflow_clr = 1'b1;
        @(negedge clk);
        rx_overflow_clr = 1'b0;
        @(negedge clk);
        chk(rx_overflow == 0, "R7 overflow cleared", rx_overflow, 0);
        rx_ready = 1'b1;
        repeat (3) @(negedge clk);

        // R10: disable in mid-frame, then resume cleanly
        pol = 2'b01; enable = 1'b1;
        load_tx(32'h0000_00FF);
        frame(8, 32'h0000_00C9, 0, 4, 0);
        repeat (3) @(negedge clk);
        chk(tx_sd == 0, "R10 tx_sd low when disabled", tx_sd, 0);
        repeat (40) @(negedge clk);
        chk(rx_valid == 0, "R10 partial word dropped", rx_valid, 0);
        enable = 1'b1;
        load_tx(32'h0000_0081);
        frame(8, 32'h0000_0042, 1, 0, 0);
        settle();
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule